// File: doc/BRIEF.md
# Decimation-Ratio Word-Rate Timer

This block paces the output words of a delta-sigma converter. Software stores an 11-bit decimation setting in two byte-wide registers on a simple register bus. While a conversion runs, the block counts modulator clock ticks and raises a one-cycle word strobe at the end of every conversion period. Each step of the ratio is worth 128 modulator ticks, and the effective ratio is the setting plus one.

A start pulse moves the block from idle to converting. At that moment it captures the setting, clamped to a floor, and clears both of its counters. Periods then follow each other with no gap until a stop pulse returns the block to idle. The ratio registers are locked while a conversion runs. A fast-filter mode flag enables a divisibility check: when the check fails, the block sets a sticky error flag and goes on counting with the clamped setting.

Top module: `wordrate_timer`

## Requirements
- R1: After reset the setting is 2047 (high register reads 0x07, low register reads 0xFF), the block is idle, the strobe is low and the error flag is clear.
- R2: The high register at address 0x9B holds setting bits 10:8 in its bits 2:0, and its bits 7:3 always read zero. The low register at address 0x9A holds setting bits 7:0. Any other address reads zero. Reads are combinational.
- R3: A register write takes effect only while the block is idle. A write while converting leaves the readback unchanged.
- R4: Each conversion period lasts (clamped setting + 1) × 128 counted ticks. The strobe is high for exactly one clock cycle, in the cycle after the clock edge that samples the period's last tick.
- R5: A setting below 19 counts as 19, so the shortest period is 20 × 128 ticks. Readback still shows the raw written value.
- R6: After a strobe the next period starts at once, and a second period has the same length as the first.
- R7: Only clock edges with the tick input high advance the count. Gaps in the tick stream stretch the period in clock cycles but not in ticks.
- R8: An accepted start captures the clamped setting and clears both counters. The edge that accepts the start counts no tick.
- R9: A stop pulse returns the block to idle on the next edge, and no strobe follows. Stop wins over a start in the same cycle.
- R10: With fast mode on and the low three bits of the clamped setting not all ones, the error flag sets on the next edge. It stays set until an accepted start reloads it with the check's current result.
- R11: A start pulse while converting is ignored and does not disturb the running period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write enable |
| addr | input | 8 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| mod_tick | input | 1 | Modulator clock tick, one clock wide per tick |
| start | input | 1 | Start conversion pulse |
| stop | input | 1 | Stop conversion pulse |
| fast_mode | input | 1 | Fast-filter mode enable |
| word_stb | output | 1 | End-of-period word strobe |
| busy | output | 1 | Converting (high) or idle (low) |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
A wrong prescale or ratio count shows up as a strobe interval that is off by whole multiples of 128 ticks or by single ticks, and it is visible at the first strobe after a start. A broken capture or clamp gives periods that follow the live register or fall below 2560 ticks. A broken write lock appears at once in the readback on the next bus read. A faulty error flag can be seen on the edge after fast mode or the setting changes.

// File: rtl/wrt_pkg.sv
package wrt_pkg;
  localparam int SET_W   = 11;
  localparam int MIN_SET = 19;
  localparam int FAST_LSB = 3;

  // floor the requested setting to the smallest legal value
  function automatic logic [SET_W-1:0] clamp_setting(input logic [SET_W-1:0] s);
    return (s < SET_W'(MIN_SET)) ? SET_W'(MIN_SET) : s;
  endfunction

  // fast filter needs ratio divisible by 8: low bits of setting all ones
  function automatic logic fast_ratio_ok(input logic [SET_W-1:0] s);
    return &s[FAST_LSB-1:0];
  endfunction
endpackage

// File: rtl/wrt_cfg_regs.sv
module wrt_cfg_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SET_W  = 11,
  parameter logic [ADDR_W-1:0] ADDR_HI = 8'h9B,
  parameter logic [ADDR_W-1:0] ADDR_LO = 8'h9A,
  parameter logic [SET_W-1:0] RESET_SET = 11'h7FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              lock,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SET_W-1:0]  setting,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_BITS = SET_W - DATA_W;

  logic wr_ok;
  assign wr_ok = wr_en && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setting <= RESET_SET;
    end else if (wr_ok) begin
      if (addr == ADDR_HI) setting[SET_W-1:DATA_W] <= wdata[HI_BITS-1:0];
      else if (addr == ADDR_LO) setting[DATA_W-1:0] <= wdata;
    end
  end

  always_comb begin
    if (addr == ADDR_HI)      rdata = {{(DATA_W-HI_BITS){1'b0}}, setting[SET_W-1:DATA_W]};
    else if (addr == ADDR_LO) rdata = setting[DATA_W-1:0];
    else                      rdata = '0;
  end
endmodule

// File: rtl/wrt_seq.sv
module wrt_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic cfg_bad,
  output logic busy,
  output logic start_acc,
  output logic err
);
  assign start_acc = start && !stop && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (stop)           busy <= 1'b0;
      else if (start_acc) busy <= 1'b1;
      if (start_acc) err <= cfg_bad;
      else           err <= err | cfg_bad;
    end
  end
endmodule

// File: rtl/wrt_period_ctr.sv
module wrt_period_ctr #(
  parameter int PRESCALE = 128,
  parameter int SET_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             mod_tick,
  input  logic [SET_W-1:0] set_in,
  output logic [SET_W-1:0] lim,
  output logic [$clog2(PRESCALE)-1:0] presc,
  output logic [SET_W-1:0] rcnt,
  output logic             word_stb
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESCALE - 1);

  logic presc_wrap, period_end;
  assign presc_wrap = run && mod_tick && (presc == PRESC_LAST);
  assign period_end = presc_wrap && (rcnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc    <= '0;
      rcnt     <= '0;
      lim      <= '0;
      word_stb <= 1'b0;
    end else begin
      word_stb <= 1'b0;
      if (restart) begin
        presc <= '0;
        rcnt  <= '0;
        lim   <= set_in;
      end else if (run && mod_tick) begin
        if (presc_wrap) begin
          presc <= '0;
          if (period_end) begin
            rcnt     <= '0;
            word_stb <= 1'b1;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end else begin
          presc <= presc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wordrate_timer.sv
module wordrate_timer #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PRESCALE = 128,
  parameter logic [ADDR_W-1:0] ADDR_HI = 8'h9B,
  parameter logic [ADDR_W-1:0] ADDR_LO = 8'h9A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              mod_tick,
  input  logic              start,
  input  logic              stop,
  input  logic              fast_mode,
  output logic              word_stb,
  output logic              busy,
  output logic              cfg_err
);
  import wrt_pkg::*;
  localparam int PW = $clog2(PRESCALE);

  logic [SET_W-1:0] setting_w, clamped_w, lim_w, rcnt_w;
  logic [PW-1:0]    presc_w;
  logic             start_acc_w, cfg_bad_w, run_w;

  assign clamped_w = clamp_setting(setting_w);
  assign cfg_bad_w = fast_mode && !fast_ratio_ok(clamped_w);
  assign run_w     = busy && !stop;

  wrt_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W),
    .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .RESET_SET({SET_W{1'b1}})
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lock(busy),
    .addr(addr), .wdata(wdata), .setting(setting_w), .rdata(rdata)
  );

  wrt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cfg_bad(cfg_bad_w), .busy(busy), .start_acc(start_acc_w), .err(cfg_err)
  );

  wrt_period_ctr #(.PRESCALE(PRESCALE), .SET_W(SET_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .restart(start_acc_w), .run(run_w),
    .mod_tick(mod_tick), .set_in(clamped_w), .lim(lim_w),
    .presc(presc_w), .rcnt(rcnt_w), .word_stb(word_stb)
  );
endmodule

// File: rtl/wrt_checks.sv
module wrt_checks #(
  parameter int SET_W = 11,
  parameter int PW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             word_stb,
  input logic             wr_en,
  input logic             stop,
  input logic             start_acc,
  input logic             err,
  input logic [SET_W-1:0] setting,
  input logic [SET_W-1:0] lim,
  input logic [PW-1:0]    presc
);
  AST_STB_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> $past(busy)); // R4
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb); // R4
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(setting)); // R3
  AST_LIM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lim >= SET_W'(wrt_pkg::MIN_SET))); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start_acc) |=> err); // R10
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (presc == '0)); // R8
endmodule

bind wordrate_timer wrt_checks #(.SET_W(wrt_pkg::SET_W), .PW($clog2(PRESCALE))) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .word_stb(word_stb), .wr_en(wr_en),
  .stop(stop), .start_acc(start_acc_w), .err(cfg_err), .setting(setting_w),
  .lim(lim_w), .presc(presc_w)
);

// File: tb/wordrate_timer_tb.sv
module wordrate_timer_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, mod_tick = 1, start = 0, stop = 0, fast_mode = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic word_stb, busy, cfg_err;
  logic gap_mode = 0;
  int n_chk = 0, n_bad = 0;

  localparam int NV = 6;
  localparam int VEC_SET [NV] = '{0, 5, 18, 19, 20, 31};
  localparam int VEC_RAT [NV] = '{20, 20, 20, 20, 21, 32};

  wordrate_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mod_tick(mod_tick), .start(start), .stop(stop),
    .fast_mode(fast_mode), .word_stb(word_stb), .busy(busy), .cfg_err(cfg_err)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (gap_mode) mod_tick <= ~mod_tick; else mod_tick <= 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output int d);
    addr = a; #1; d = rdata;
  endtask

  task automatic start_pulse();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic stop_pulse();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  // count ticks from now until strobe; optionally pulse start at tick inj
  task automatic measure(input int inj, output int ticks);
    ticks = 0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (mod_tick) ticks++;
      @(negedge clk);
      start = (ticks == inj);
      if (word_stb) begin start = 0; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int d, t1, t2, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    reg_read(8'h9B, d); chk("R1 hi reset", d, 7);
    reg_read(8'h9A, d); chk("R1 lo reset", d, 255);
    chk("R1 busy", busy, 0); chk("R1 strobe", word_stb, 0); chk("R1 err", cfg_err, 0);
    // R2 register map
    reg_read(8'h00, d); chk("R2 unmapped", d, 0);
    reg_write(8'h9B, 8'hF8); reg_read(8'h9B, d); chk("R2 hi upper ignored", d, 0);
    reg_write(8'h9B, 8'hFD); reg_read(8'h9B, d); chk("R2 hi low bits", d, 5);
    reg_write(8'h9A, 8'h3C); reg_read(8'h9A, d); chk("R2 lo", d, 8'h3C);

    // vector table: R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      reg_write(8'h9B, 8'(VEC_SET[v] >> 8));
      reg_write(8'h9A, 8'(VEC_SET[v]));
      reg_read(8'h9A, d); chk("R5 raw readback", d, VEC_SET[v] & 255);
      start_pulse();
      measure(-1, t1); chk("R4 first period", t1, VEC_RAT[v] * 128);
      measure(-1, t2); chk("R6 second period", t2, VEC_RAT[v] * 128);
      stop_pulse();
    end

    // R7 tick gaps
    reg_write(8'h9B, 0); reg_write(8'h9A, 19);
    gap_mode = 1;
    start_pulse();
    cnt = 0; t1 = 0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); cnt++; if (mod_tick) t1++;
      @(negedge clk); if (word_stb) break;
    end
    chk("R7 ticks with gaps", t1, 2560);
    chk("R7 cycles stretched", (cnt > 5000) ? 1 : 0, 1);
    stop_pulse();
    gap_mode = 0;

    // R11 start while busy, R4 width, R3 lock
    start_pulse();
    measure(1000, t1); chk("R11 period with extra start", t1, 2560);
    @(negedge clk); chk("R4 strobe one cycle", word_stb, 0);
    chk("R11 still busy", busy, 1);
    reg_write(8'h9A, 8'h55); reg_read(8'h9A, d); chk("R3 write locked", d, 19);
    // R9 stop
    stop_pulse(); chk("R9 idle after stop", busy, 0);
    cnt = 0;
    repeat (3000) begin @(negedge clk); if (word_stb) cnt++; end
    chk("R9 no strobe after stop", cnt, 0);
    @(negedge clk); start = 1; stop = 1;
    @(negedge clk); start = 0; stop = 0;
    chk("R9 stop beats start", busy, 0);
    reg_write(8'h9A, 8'h55); reg_read(8'h9A, d); chk("R3 write when idle", d, 8'h55);

    // R10 fast mode error flag
    reg_write(8'h9A, 19);
    fast_mode = 1;
    @(negedge clk); chk("R10 err set", cfg_err, 1);
    reg_write(8'h9A, 23);
    @(negedge clk); chk("R10 err sticky", cfg_err, 1);
    start_pulse(); chk("R10 err cleared on start", cfg_err, 0);
    measure(-1, t1); chk("R10 fast period", t1, 24 * 128);
    stop_pulse();
    fast_mode = 0;

    summary();
    $finish;
  end
endmodule